// File: doc/BRIEF.md
# Multi-Mode Configurable Logic Cell

This block is one logic cell of a programmable fabric. Sixteen storage bits sit behind a four-input read path. The same bits serve one of three roles, chosen by a two-bit mode field:

- **Function mode:** they form a fixed truth table, and the inputs pick one bit.
- **Shift mode:** they form a sixteen-stage shift line, and the inputs pick which stage drives the output. This gives a delay line of selectable length.
- **RAM mode:** they form a one-bit-wide memory with a synchronous write and an asynchronous read.

The looked-up bit leaves the cell directly. It also feeds a flip-flop that has a clock enable, a set/reset input and a configured start value. A final selector chooses whether the cell output is the raw looked-up bit or the registered bit.

All settings arrive through a serial configuration chain while a load strobe is held high. The settings are the table contents, the mode, the flip-flop start value, the flip-flop's active clock edge and the output selection. The chain's far end is brought out, so several cells can be chained and read back. Loading holds normal operation off. Reset acts only on the flip-flop. The configuration is kept through reset.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `cfg_en` is high, each rising edge shifts `cfg_sin` into storage bit 0 and moves every bit of the 21-bit chain up by one. `cfg_sout` always shows chain bit 20. The chain layout is:
  - bits 15:0: table or storage contents
  - bits 17:16: mode
  - bit 18: flip-flop start value
  - bit 19: falling-edge select
  - bit 20: registered-output select

  A word sent most significant bit first therefore lands in place after 21 edges.
- R2: In mode 00 (function), `lut_o` equals storage bit `lut_a` at all times.
- R3: In mode 01 (shift), each rising edge with `ce` high shifts `d_in` into bit 0 and moves bit i to bit i+1. `lut_o` shows bit `lut_a`, so the tap at address k gives the input from k+1 enabled edges earlier.
- R4: In mode 10 (RAM), a rising edge with `ce` and `wr_en` both high writes `d_in` into bit `lut_a`. The read through `lut_o` is asynchronous.
- R5: The storage never changes in the following cases:
  - in mode 00 or mode 11, whatever the other inputs do
  - in RAM mode unless `ce` and `wr_en` are both high
  - in shift mode unless `ce` is high
  - from `d_in`, `ce` or `wr_en` while `cfg_en` is high
- R6: With bit 20 set, `cell_o` equals `q_o`. With bit 20 clear, `cell_o` equals `lut_o`. `q_o` always shows the flip-flop.
- R7: On its active edge with `ce` high, the flip-flop takes `lut_o`. With `ce` low it holds.
- R8: With bit 19 clear the flip-flop acts on rising edges. With bit 19 set it acts on falling edges and ignores rising ones.
- R9: `sr` high on an active edge loads the start value (bit 18), and this has priority over `ce`.
- R10: `rst_n` low on an active edge loads the start value into the flip-flop and leaves all configuration and storage unchanged.
- R11: While `cfg_en` is high, and on the first active edge after it falls, the flip-flop loads the start value. A finished load therefore leaves `q_o` at the new start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flop |
| lut_a | input | LUT_K | Table address, shift tap or RAM address |
| d_in | input | 1 | Shift data or RAM write data |
| wr_en | input | 1 | RAM write enable |
| ce | input | 1 | Clock enable for storage updates and the flip-flop |
| sr | input | 1 | Set/reset of the flip-flop to its start value |
| cfg_en | input | 1 | Configuration load strobe |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (top chain bit) |
| lut_o | output | 1 | Looked-up storage bit |
| cell_o | output | 1 | Cell output after the output selector |
| q_o | output | 1 | Flip-flop output |

## Verification
The bench builds the cell with its default of four inputs and therefore sixteen storage bits. Every table address, every shift tap after each push and every RAM location is compared against a model that is small enough to sweep in full. The 21-bit chain is short enough to send and read back bit by bit. This covers the field layout and the daisy-chain output completely. Both clock-edge settings, both output selections, and the priorities of set/reset and reset over the enable are each exercised on this same small cell.

// File: rtl/cfg_cell_pkg.sv
`timescale 1ns/1ps
// Shared types of the configurable logic cell: the storage mode encoding
// and the packed control field that sits above the storage bits in the
// configuration chain. Assumes the chain order use_ff, neg_edge, ff_init,
// mode from most to least significant bit.
package cfg_cell_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC  = 2'b00,
        MODE_SHIFT = 2'b01,
        MODE_RAM   = 2'b10,
        MODE_RSVD  = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic       use_ff;
        logic       neg_edge;
        logic       ff_init;
        cell_mode_e mode;
    } cell_ctrl_t;

    localparam int CTRL_W = $bits(cell_ctrl_t);

endpackage

// File: rtl/cell_store.sv
`timescale 1ns/1ps
// Sixteen-style storage of the cell (DEPTH bits). The bits form the low part
// of the configuration chain and are also written in shift and RAM modes.
// Assumes cfg_en has priority over user writes; the contents are
// configuration and are deliberately not cleared by reset.
module cell_store
    import cfg_cell_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              cfg_en,
    input  logic              cfg_sin,
    input  cell_mode_e        mode,
    input  logic              ce,
    input  logic              wr_en,
    input  logic              d_in,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  cells,
    output logic              chain_out
);

    // Configuration shift, then shift-line push or RAM write.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            cells <= {cells[DEPTH-2:0], cfg_sin};
        end else if (ce) begin
            case (mode)
                MODE_SHIFT: cells <= {cells[DEPTH-2:0], d_in};
                MODE_RAM:   if (wr_en) cells[addr] <= d_in;
                default:    cells <= cells;
            endcase
        end
    end

    assign chain_out = cells[DEPTH-1];

endmodule

// File: rtl/cell_ctrl_chain.sv
`timescale 1ns/1ps
// Upper part of the configuration chain holding the control field, plus a
// one-cycle delayed copy of the load strobe used to settle the flip-flop.
// Assumes chain_in comes from the top storage bit.
module cell_ctrl_chain
    import cfg_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       chain_in,
    output cell_ctrl_t ctrl,
    output logic       cfg_en_d,
    output logic       cfg_sout
);

    // Shift the control field while loading; it survives reset.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            ctrl <= cell_ctrl_t'({ctrl[CTRL_W-2:0], chain_in});
        end
    end

    // Remember that a load was in progress on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en_d <= 1'b0;
        end else begin
            cfg_en_d <= cfg_en;
        end
    end

    assign cfg_sout = ctrl[CTRL_W-1];

endmodule

// File: rtl/cell_read_tree.sv
`timescale 1ns/1ps
// Asynchronous read of one storage bit through a binary tree of 2:1
// selectors, one level per address bit, least significant bit first.
// Assumes DEPTH equals 2**ADDR_W.
module cell_read_tree #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic [DEPTH-1:0]  cells,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd
);

    for (genvar lv = 0; lv <= ADDR_W; lv++) begin : g_lvl
        logic [(DEPTH >> lv)-1:0] v;
        if (lv == 0) begin : g_leaf
            assign v = cells;
        end else begin : g_node
            for (genvar k = 0; k < (DEPTH >> lv); k++) begin : g_sel
                assign v[k] = addr[lv-1] ? g_lvl[lv-1].v[2*k+1]
                                         : g_lvl[lv-1].v[2*k];
            end
        end
    end

    assign rd = g_lvl[ADDR_W].v[0];

endmodule

// File: rtl/cell_out_reg.sv
`timescale 1ns/1ps
// Output flip-flop of the cell. One capture register per clock edge; the
// configured edge picks which one is seen. Reset, set/reset and loading all
// force the start value. Assumes rst_n is synchronous to both edges.
module cell_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sr,
    input  logic load_init,
    input  logic init_val,
    input  logic neg_edge,
    input  logic d,
    output logic q_pos,
    output logic q_neg,
    output logic q
);

    logic force_init;
    assign force_init = !rst_n || load_init || sr;

    // Rising-edge capture with init priority over enable.
    always_ff @(posedge clk) begin
        if (force_init) begin
            q_pos <= init_val;
        end else if (ce) begin
            q_pos <= d;
        end
    end

    // Falling-edge capture with the same priorities.
    always_ff @(negedge clk) begin
        if (force_init) begin
            q_neg <= init_val;
        end else if (ce) begin
            q_neg <= d;
        end
    end

    assign q = neg_edge ? q_neg : q_pos;

endmodule

// File: rtl/cfg_logic_cell.sv
`timescale 1ns/1ps
// Configurable logic cell: LUT_K-input storage used as truth table, tapped
// shift line or small RAM, followed by a configurable flip-flop and an
// output selector. All settings come in over a serial chain (storage bits
// first, control field on top). Assumes a single clock.
module cfg_logic_cell
    import cfg_cell_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LUT_K-1:0] lut_a,
    input  logic             d_in,
    input  logic             wr_en,
    input  logic             ce,
    input  logic             sr,
    input  logic             cfg_en,
    input  logic             cfg_sin,
    output logic             cfg_sout,
    output logic             lut_o,
    output logic             cell_o,
    output logic             q_o
);

    localparam int DEPTH = 1 << LUT_K;

    logic [DEPTH-1:0] cells;
    logic             chain_mid;
    cell_ctrl_t       ctrl;
    logic             cfg_en_d;
    logic             q_pos;
    logic             q_neg;

    cell_store #(.DEPTH(DEPTH), .ADDR_W(LUT_K)) u_store (
        .clk       (clk),
        .cfg_en    (cfg_en),
        .cfg_sin   (cfg_sin),
        .mode      (ctrl.mode),
        .ce        (ce),
        .wr_en     (wr_en),
        .d_in      (d_in),
        .addr      (lut_a),
        .cells     (cells),
        .chain_out (chain_mid)
    );

    cell_ctrl_chain u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .chain_in (chain_mid),
        .ctrl     (ctrl),
        .cfg_en_d (cfg_en_d),
        .cfg_sout (cfg_sout)
    );

    cell_read_tree #(.DEPTH(DEPTH), .ADDR_W(LUT_K)) u_read (
        .cells (cells),
        .addr  (lut_a),
        .rd    (lut_o)
    );

    cell_out_reg u_ff (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .sr        (sr),
        .load_init (cfg_en || cfg_en_d),
        .init_val  (ctrl.ff_init),
        .neg_edge  (ctrl.neg_edge),
        .d         (lut_o),
        .q_pos     (q_pos),
        .q_neg     (q_neg),
        .q         (q_o)
    );

    assign cell_o = ctrl.use_ff ? q_o : lut_o;

endmodule

// File: rtl/cell_checker.sv
`timescale 1ns/1ps
// Property checker for cfg_logic_cell, attached by bind. Observes ports
// and internal storage, control field and rising-edge capture register.
module cell_checker
    import cfg_cell_pkg::*;
#(
    parameter int LUT_K = 4,
    parameter int DEPTH = 1 << LUT_K
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LUT_K-1:0] lut_a,
    input logic             d_in,
    input logic             wr_en,
    input logic             ce,
    input logic             sr,
    input logic             cfg_en,
    input logic             cfg_sin,
    input logic             cfg_sout,
    input logic             lut_o,
    input logic             cell_o,
    input logic [DEPTH-1:0] cells,
    input cell_ctrl_t       ctrl,
    input logic             cfg_en_d,
    input logic             q_pos
);

    // R1: chain moves one place per loading edge
    p_chain_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cells[0] == $past(cfg_sin)) && (cfg_sout == $past(ctrl[CTRL_W-2])));

    // R3: shift line push
    p_shift_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_SHIFT && ce && !cfg_en)
        |=> cells == {$past(cells[DEPTH-2:0]), $past(d_in)});

    // R4: RAM write lands at the address
    p_ram_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_RAM && ce && wr_en && !cfg_en)
        |=> cells[$past(lut_a)] == $past(d_in));

    // R5: function and reserved modes leave storage alone
    p_table_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl.mode == MODE_FUNC || ctrl.mode == MODE_RSVD) && !cfg_en)
        |=> $stable(cells));

    // R7: registered output follows the looked-up bit
    p_ff_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.use_ff && !ctrl.neg_edge && ce && !sr && !cfg_en && !cfg_en_d)
        |=> cell_o == $past(lut_o));

    // R7: disabled flip-flop holds
    p_ff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !sr && !cfg_en && !cfg_en_d) |=> $stable(q_pos));

    // R9: set/reset loads the start value
    p_sr_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr && !cfg_en) |=> q_pos == $past(ctrl.ff_init));

endmodule

bind cfg_logic_cell cell_checker #(.LUT_K(LUT_K)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lut_a    (lut_a),
    .d_in     (d_in),
    .wr_en    (wr_en),
    .ce       (ce),
    .sr       (sr),
    .cfg_en   (cfg_en),
    .cfg_sin  (cfg_sin),
    .cfg_sout (cfg_sout),
    .lut_o    (lut_o),
    .cell_o   (cell_o),
    .cells    (cells),
    .ctrl     (ctrl),
    .cfg_en_d (cfg_en_d),
    .q_pos    (q_pos)
);

// File: tb/cfg_logic_cell_bench.sv
`timescale 1ns/1ps
module cfg_logic_cell_bench;

    localparam int K  = 4;
    localparam int N  = 1 << K;
    localparam int CW = N + 5;

    logic         clk = 1'b0;
    logic         rst_n, d_in, wr_en, ce, sr, cfg_en, cfg_sin;
    logic [K-1:0] lut_a;
    logic         cfg_sout, lut_o, cell_o, q_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cfg_logic_cell #(.LUT_K(K)) u_cfg_logic_cell (
        .clk(clk), .rst_n(rst_n), .lut_a(lut_a), .d_in(d_in), .wr_en(wr_en),
        .ce(ce), .sr(sr), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
        .cfg_sout(cfg_sout), .lut_o(lut_o), .cell_o(cell_o), .q_o(q_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [CW-1:0] word(input logic uf, input logic ng,
                                           input logic ini, input logic [1:0] md,
                                           input logic [N-1:0] tb);
        return {uf, ng, ini, md, tb};
    endfunction

    // Send a configuration word MSB first, then one settling edge.
    task automatic load(input logic [CW-1:0] w);
        cfg_en = 1'b1;
        for (int i = CW - 1; i >= 0; i--) begin
            cfg_sin = w[i];
            tick();
        end
        cfg_en = 1'b0; cfg_sin = 1'b0; ce = 1'b0; wr_en = 1'b0; sr = 1'b0;
        tick();
    endtask

    task automatic sweep(input string req, input logic [N-1:0] exp);
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a);
            #1;
            chk(req, lut_o, exp[a]);
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0]  tt, t2, model, pat;
        logic [CW-1:0] w;
        logic          prev, bitv;
        tt = 16'hB6D1;
        for (int i = 0; i < N; i++) t2[i] = (i[0] & i[1]) | i[2];
        pat = 16'h3A5C;
        rst_n = 1'b0; d_in = 0; wr_en = 0; ce = 0; sr = 0; cfg_en = 0; cfg_sin = 0; lut_a = '0;
        tick(); tick();
        rst_n = 1'b1;

        // Registered output, rising edge, start value 1
        load(word(1'b1, 1'b0, 1'b1, 2'b00, tt));
        chk("R11", q_o, 1'b1);
        chk("R6", cell_o, 1'b1);
        ce = 1'b1; prev = 1'b1;
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a);
            #1;
            chk("R7", q_o, prev);
            chk("R2", lut_o, tt[a]);
            tick();
            chk("R7", q_o, tt[a]);
            chk("R6", cell_o, tt[a]);
            prev = tt[a];
        end
        ce = 1'b0; lut_a = 4'd1; tick();
        chk("R7", q_o, prev);
        ce = 1'b1; sr = 1'b1; tick();
        chk("R9", q_o, 1'b1);
        sr = 1'b0; tick();
        chk("R7", q_o, 1'b0);
        rst_n = 1'b0; tick();
        chk("R10", q_o, 1'b1);
        rst_n = 1'b1; ce = 1'b0;
        sweep("R10", tt);

        // Combinational output selection
        load(word(1'b0, 1'b0, 1'b1, 2'b00, tt));
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a);
            #1;
            chk("R6", cell_o, tt[a]);
            chk("R6", q_o, 1'b1);
        end

        // Falling-edge flip-flop, start value 0
        load(word(1'b1, 1'b1, 1'b0, 2'b00, tt));
        chk("R11", q_o, 1'b0);
        ce = 1'b1; prev = 1'b0;
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a);
            #1;
            chk("R8", q_o, prev);
            @(negedge clk);
            #2;
            chk("R8", q_o, tt[a]);
            prev = tt[a];
            tick();
        end
        ce = 1'b0;

        // Function mode with a second table; writes ignored
        load(word(1'b0, 1'b0, 1'b0, 2'b00, t2));
        sweep("R2", t2);
        ce = 1'b1; wr_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            lut_a = K'(i * 3); d_in = ~t2[i * 3]; tick();
        end
        ce = 1'b0; wr_en = 1'b0;
        sweep("R5", t2);

        // Reserved mode behaves as a frozen table
        load(word(1'b0, 1'b0, 1'b0, 2'b11, 16'h5AA5));
        ce = 1'b1; wr_en = 1'b1; d_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            lut_a = K'(i); tick();
        end
        ce = 1'b0; wr_en = 1'b0;
        sweep("R5", 16'h5AA5);

        // Shift mode: tap k gives input from k+1 pushes ago
        load(word(1'b0, 1'b0, 1'b0, 2'b01, 16'h8001));
        model = 16'h8001;
        for (int k = 0; k < 24; k++) begin
            bitv = 1'(((k * 5 + 3) >> 2) & 1);
            d_in = bitv; ce = 1'b1;
            tick();
            ce = 1'b0;
            model = {model[N-2:0], bitv};
            sweep("R3", model);
        end
        d_in = ~model[0]; tick(); tick();
        sweep("R5", model);

        // RAM mode: user writes blocked during loading
        ce = 1'b1; wr_en = 1'b1; d_in = 1'b1;
        load(word(1'b0, 1'b0, 1'b0, 2'b10, 16'h0F0F));
        sweep("R5", 16'h0F0F);
        ce = 1'b1; wr_en = 1'b1;
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a); d_in = pat[a]; tick();
        end
        ce = 1'b0; wr_en = 1'b0;
        sweep("R4", pat);
        ce = 1'b1; wr_en = 1'b0;
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a); d_in = ~pat[a]; tick();
        end
        ce = 1'b0; wr_en = 1'b1;
        for (int a = 0; a < N; a++) begin
            lut_a = K'(a); d_in = ~pat[a]; tick();
        end
        wr_en = 1'b0;
        sweep("R5", pat);

        // Serial readback of a whole word
        w = word(1'b1, 1'b0, 1'b1, 2'b10, 16'hC35A);
        load(w);
        sweep("R1", 16'hC35A);
        cfg_en = 1'b1; cfg_sin = 1'b0;
        for (int i = 0; i < CW; i++) begin
            chk("R1", cfg_sout, w[CW-1-i]);
            tick();
        end
        cfg_en = 1'b0;
        chk("R1", cfg_sout, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule